// File: doc/BRIEF.md
# Dual-Clock Ready-Flag FIFO

This block buffers 36-bit words between two unrelated clock domains. A producer on the write clock (port A) pushes words. A consumer on the read clock (port B) takes them from a registered output that refills itself. Each side sees only flags that are registered in its own clock domain. `in_rdy` means a word may be written, and `out_rdy` means the output register holds a valid word.

An access on either port is performed only when several select inputs agree. On port A these are an active-low chip select, a direction input, an enable and a mailbox select. Port B has the same four, with the direction input set high to read. Two output-enable signals report when each port would drive its data bus. The output register works in fall-through mode: when it is empty and a word is stored, the word is loaded without any request, and `out_rdy` rises on the same edge. Two threshold flags, almost-empty and almost-full, compare the fill level with offset inputs. The block can hold DEPTH words in memory plus one word in the output register.

Top module: `rdy_fifo`

## Requirements
- R1: A word on `din_a` is stored at a rising `clk_a` edge only when `cs_a_n`=0, `mb_a`=0, `dir_a`=1, `en_a`=1 and `in_rdy`=1. If any one of these conditions is missing, nothing is stored.
- R2: While `out_rdy`=1, the word in the output register is consumed at a rising `clk_b` edge only when `cs_b_n`=0, `mb_b`=0, `dir_b`=1 and `en_b`=1. Otherwise `dout_b` and `out_rdy` hold their values.
- R3: While `out_rdy`=0 and a word is stored, that word is loaded into `dout_b` with no read request, and `out_rdy` rises on the same `clk_b` edge.
- R4: `oe_a` is 1 exactly when `cs_a_n`=0 and `dir_a`=0. `oe_b` is 1 exactly when `cs_b_n`=0 and `dir_b`=1.
- R5: While `rst_n`=0 (asynchronous), `in_rdy`=0, `out_rdy`=0, `aempty_n`=0 and `afull_n`=1, and both pointers are cleared.
- R6: After `rst_n` is released between edges, `in_rdy` is still 0 after the first rising `clk_a` edge and is 1 after the second.
- R7: With no reads, continuous write attempts are accepted for exactly DEPTH+1 words (512 memory words plus the output register). After that, `in_rdy` stays 0 and extra writes are dropped.
- R8: After the last held word is consumed, `out_rdy` falls to 0 and stays 0 under further read requests, and nothing is lost or repeated.
- R9: `aempty_n` is 0 while the number of held words (memory plus output register) is at or below `off_ae`, and 1 above it, once the flags have settled.
- R10: `afull_n` is 0 while the free memory space (DEPTH minus words not yet moved to the output register) is at or below `off_af`, and 1 above it, once the flags have settled.
- R11: Under concurrent random traffic on both ports, every accepted word is read out exactly once and in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a_n | input | 1 | Port A chip select, active low |
| dir_a | input | 1 | Port A direction, 1 = write |
| en_a | input | 1 | Port A enable |
| mb_a | input | 1 | Port A mailbox select, must be 0 for FIFO access |
| din_a | input | 36 | Write data |
| off_ae | input | 9 | Almost-empty threshold |
| off_af | input | 9 | Almost-full threshold |
| oe_a | output | 1 | Port A data bus would be driven |
| in_rdy | output | 1 | A write will be accepted |
| afull_n | output | 1 | Low when free space is at or below threshold |
| cs_b_n | input | 1 | Port B chip select, active low |
| dir_b | input | 1 | Port B direction, 1 = read |
| en_b | input | 1 | Port B enable |
| mb_b | input | 1 | Port B mailbox select, must be 0 for FIFO access |
| dout_b | output | 36 | Output register |
| oe_b | output | 1 | Port B data bus would be driven |
| out_rdy | output | 1 | Output register holds a valid word |
| aempty_n | output | 1 | Low when held words are at or below threshold |

## Verification
The output enables are combinational and are checked one nanosecond after their inputs change. `in_rdy` changes on the second `clk_a` edge after reset release, and it is sampled at the falling edges just after the first and second rising edges. A write counts as accepted when `in_rdy` is high at the falling edge before the rising edge that stores it. A read counts as consuming the shown word when `out_rdy` is high at the falling edge before its rising edge, so data is compared at the cycle where the consumer takes it and never at a guessed latency. A change on one side reaches the other side's flags through a register, two synchronizer stages and a flag register. The threshold, full and empty checks therefore first let both ports idle for twenty read-clock cycles, which is several times that worst-case latency.

// File: rtl/rdy_fifo.sv
module rdy_fifo #(
  parameter int DW = 36,
  parameter int AW = 9
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          cs_a_n,
  input  logic          dir_a,
  input  logic          en_a,
  input  logic          mb_a,
  input  logic [DW-1:0] din_a,
  input  logic [AW-1:0] off_ae,
  input  logic [AW-1:0] off_af,
  output logic          oe_a,
  output logic          in_rdy,
  output logic          afull_n,
  input  logic          cs_b_n,
  input  logic          dir_b,
  input  logic          en_b,
  input  logic          mb_b,
  output logic [DW-1:0] dout_b,
  output logic          oe_b,
  output logic          out_rdy,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  assign oe_a = ~cs_a_n & ~dir_a;
  assign oe_b = ~cs_b_n & dir_b;

  // write side
  logic          a_live;
  logic [AW:0]   wbin, wgray, rg1, rg2;
  logic          wr_go;
  logic [AW:0]   wbin_nxt, wgray_nxt, used_a, free_a;

  assign wr_go     = in_rdy & ~cs_a_n & ~mb_a & dir_a & en_a;
  assign wbin_nxt  = wbin + {{AW{1'b0}}, wr_go};
  assign wgray_nxt = (wbin_nxt >> 1) ^ wbin_nxt;
  assign used_a    = wbin_nxt - g2b(rg2);
  assign free_a    = PW'(DEPTH) - used_a;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      a_live  <= 1'b0;
      wbin    <= '0;
      wgray   <= '0;
      rg1     <= '0;
      rg2     <= '0;
      in_rdy  <= 1'b0;
      afull_n <= 1'b1;
    end else begin
      a_live  <= 1'b1;
      rg1     <= rgray;
      rg2     <= rg1;
      wbin    <= wbin_nxt;
      wgray   <= wgray_nxt;
      in_rdy  <= a_live & (wgray_nxt != {~rg2[AW:AW-1], rg2[AW-2:0]});
      afull_n <= free_a > {1'b0, off_af};
    end
  end

  always_ff @(posedge clk_a) begin
    if (wr_go) mem[wbin[AW-1:0]] <= din_a;
  end

  // read side
  logic          b_live;
  logic [AW:0]   rbin, rgray, wg1, wg2;
  logic          rd_req, avail, take, ordy_nxt;
  logic [AW:0]   rbin_nxt, level_b;

  assign rd_req   = ~cs_b_n & ~mb_b & dir_b & en_b;
  assign avail    = rgray != wg2;
  assign take     = b_live & avail & (~out_rdy | rd_req);
  assign ordy_nxt = take | (out_rdy & ~rd_req);
  assign rbin_nxt = rbin + {{AW{1'b0}}, take};
  assign level_b  = g2b(wg2) - rbin_nxt + {{AW{1'b0}}, ordy_nxt};

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      b_live   <= 1'b0;
      rbin     <= '0;
      rgray    <= '0;
      wg1      <= '0;
      wg2      <= '0;
      out_rdy  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      b_live   <= 1'b1;
      wg1      <= wgray;
      wg2      <= wg1;
      rbin     <= rbin_nxt;
      rgray    <= (rbin_nxt >> 1) ^ rbin_nxt;
      out_rdy  <= ordy_nxt;
      aempty_n <= level_b > {1'b0, off_ae};
    end
  end

  always_ff @(posedge clk_b) begin
    if (take) dout_b <= mem[rbin[AW-1:0]];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_a) disable iff (!rst_n)
    (wbin - g2b(rg2)) <= PW'(DEPTH)); // R7
  AST_GRAY_STEP: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray))); // R11
  AST_AUTO_LOAD: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_live && !out_rdy && avail |=> out_rdy); // R3
  AST_HOLD_WORD: assert property (@(posedge clk_b) disable iff (!rst_n)
    out_rdy && !rd_req |=> out_rdy && $stable(dout_b)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_b) disable iff (!rst_n)
    (g2b(wg2) - rbin) <= PW'(DEPTH)); // R8
endmodule

// File: tb/rdy_fifo_tb.sv
`timescale 1ns/1ps
module rdy_fifo_tb;
  localparam int DW = 36;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic cs_a_n = 1, dir_a = 1, en_a = 0, mb_a = 0;
  logic cs_b_n = 1, dir_b = 1, en_b = 0, mb_b = 0;
  logic [DW-1:0] din_a = '0;
  logic [AW-1:0] off_ae = 9'd4, off_af = 9'd8;
  logic oe_a, in_rdy, afull_n, oe_b, out_rdy, aempty_n;
  logic [DW-1:0] dout_b;

  int n_chk = 0, n_bad = 0, wr_cnt = 0;
  bit done = 0;
  logic [DW-1:0] q[$];

  always #4 clk_a = ~clk_a;
  always #5.5 clk_b = ~clk_b;

  rdy_fifo #(.DW(DW), .AW(AW)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .cs_a_n(cs_a_n), .dir_a(dir_a), .en_a(en_a), .mb_a(mb_a), .din_a(din_a),
    .off_ae(off_ae), .off_af(off_af), .oe_a(oe_a), .in_rdy(in_rdy), .afull_n(afull_n),
    .cs_b_n(cs_b_n), .dir_b(dir_b), .en_b(en_b), .mb_b(mb_b), .dout_b(dout_b),
    .oe_b(oe_b), .out_rdy(out_rdy), .aempty_n(aempty_n));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit wr_ok(logic cs, logic mb, logic dir, logic en);
    return !cs && !mb && dir && en;
  endfunction

  task automatic a_cycle(input logic cs, input logic mb, input logic dir, input logic en, input logic [DW-1:0] d);
    @(negedge clk_a);
    cs_a_n = cs; mb_a = mb; dir_a = dir; en_a = en; din_a = d;
    if (in_rdy && wr_ok(cs, mb, dir, en)) begin
      q.push_back(d);
      wr_cnt++;
    end
  endtask

  task automatic b_cycle(input logic cs, input logic mb, input logic dir, input logic en, input string tag);
    logic [DW-1:0] e;
    @(negedge clk_b);
    cs_b_n = cs; mb_b = mb; dir_b = dir; en_b = en;
    if (out_rdy && wr_ok(cs, mb, dir, en)) begin
      if (q.size() == 0) chk(tag, "read with nothing expected", 1, 0);
      else begin
        e = q.pop_front();
        chk(tag, "read data", dout_b, e);
      end
    end
  endtask

  task automatic settle();
    a_cycle(1, 0, 1, 0, '0);
    b_cycle(1, 0, 1, 0, "idle");
    repeat (20) @(negedge clk_b);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 4000 && q.size() > 0; i++) b_cycle(0, 0, 1, 1, tag);
    b_cycle(1, 0, 1, 0, tag);
  endtask

  function automatic logic rbad(int n);
    return ($urandom % n) == 0;
  endfunction

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk_a);
    chk("R5", "in_rdy in reset", in_rdy, 0);
    chk("R5", "out_rdy in reset", out_rdy, 0);
    chk("R5", "aempty_n in reset", aempty_n, 0);
    chk("R5", "afull_n in reset", afull_n, 1);
    rst_n = 1;
    @(negedge clk_a);
    chk("R6", "in_rdy after one edge", in_rdy, 0);
    @(negedge clk_a);
    chk("R6", "in_rdy after two edges", in_rdy, 1);

    for (int c = 0; c < 4; c++) begin
      cs_a_n = c[0]; dir_a = c[1]; cs_b_n = c[0]; dir_b = c[1];
      #1;
      chk("R4", "oe_a", oe_a, (!c[0] && !c[1]));
      chk("R4", "oe_b", oe_b, (!c[0] && c[1]));
    end
    cs_a_n = 1; dir_a = 1; cs_b_n = 1; dir_b = 1;

    a_cycle(1, 0, 1, 1, 36'h1);
    a_cycle(0, 1, 1, 1, 36'h2);
    a_cycle(0, 0, 0, 1, 36'h3);
    a_cycle(0, 0, 1, 0, 36'h4);
    settle();
    chk("R1", "out_rdy after disqualified writes", out_rdy, 0);
    a_cycle(0, 0, 1, 1, 36'hA5A5A5A5A);
    settle();
    chk("R3", "out_rdy after auto load", out_rdy, 1);
    chk("R3", "dout_b after auto load", dout_b, 36'hA5A5A5A5A);
    chk("R9", "aempty_n with 1 held", aempty_n, 0);

    b_cycle(1, 0, 1, 1, "R2");
    b_cycle(0, 1, 1, 1, "R2");
    b_cycle(0, 0, 0, 1, "R2");
    b_cycle(0, 0, 1, 0, "R2");
    settle();
    chk("R2", "out_rdy after disqualified reads", out_rdy, 1);
    chk("R2", "dout_b after disqualified reads", dout_b, 36'hA5A5A5A5A);

    for (int i = 0; i < 3; i++) a_cycle(0, 0, 1, 1, 36'h100 + 36'(i));
    settle();
    chk("R9", "aempty_n with 4 held", aempty_n, 0);
    a_cycle(0, 0, 1, 1, 36'h200);
    settle();
    chk("R9", "aempty_n with 5 held", aempty_n, 1);
    drain("R2");
    settle();
    chk("R8", "out_rdy after drain", out_rdy, 0);
    chk("R9", "aempty_n after drain", aempty_n, 0);
    for (int i = 0; i < 10; i++) b_cycle(0, 0, 1, 1, "R8");
    b_cycle(1, 0, 1, 0, "R8");
    chk("R8", "out_rdy after empty reads", out_rdy, 0);
    chk("R8", "nothing pending", q.size(), 0);

    wr_cnt = 0;
    for (int i = 0; i < 600; i++) a_cycle(0, 0, 1, 1, 36'h5000 + 36'(i));
    settle();
    chk("R7", "accepted writes when full", wr_cnt, DEPTH + 1);
    chk("R7", "in_rdy when full", in_rdy, 0);
    chk("R10", "afull_n when full", afull_n, 0);
    for (int i = 0; i < 8; i++) b_cycle(0, 0, 1, 1, "R7");
    settle();
    chk("R10", "afull_n with 8 free", afull_n, 0);
    b_cycle(0, 0, 1, 1, "R7");
    settle();
    chk("R10", "afull_n with 9 free", afull_n, 1);
    chk("R7", "in_rdy with space", in_rdy, 1);
    drain("R7");
    settle();
    chk("R8", "out_rdy after full drain", out_rdy, 0);

    fork
      begin
        for (int i = 0; i < 3000; i++)
          a_cycle(rbad(8), rbad(8), !rbad(8), !rbad(4), {4'($urandom), 32'($urandom)});
        a_cycle(1, 0, 1, 0, '0);
      end
      begin
        for (int i = 0; i < 3000; i++)
          b_cycle(rbad(8), rbad(8), !rbad(8), !rbad(3), "R11");
        b_cycle(1, 0, 1, 0, "R11");
      end
    join
    settle();
    drain("R11");
    settle();
    chk("R11", "words left after random traffic", q.size(), 0);
    chk("R11", "out_rdy after random drain", out_rdy, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule